// File: doc/BRIEF.md
# I/O Subchannel Status Tracker

This block holds the error and condition status of one I/O subchannel for the length of a transfer. The channel and the device report events as one-cycle strobes: channel end, byte count exhausted, data parity or overrun, memory parity during data movement, a nonexistent address, a parity error on a command fetch, and each fetched command, tagged as a transfer-in-channel command or not. The tracker turns these into sticky status bits. Using the suppress-length and halt-on-error flags of the most recently fetched command, it decides when the device must be halted.

A successful start instruction opens a transfer and clears all status. A successful halt instruction also clears all status and closes the transfer. A two-bit condition code tells the issuing processor whether the controller is ready, not operational, held by another processor, or busy with the transfer it accepted.

Top module: `sch_status_tracker`

## Requirements
- R1: After a synchronous reset, `status` is 0, `halt_req` is 0 and `cond_code` is 00 (ready).
- R2: A start (`start_ok`) makes the transfer active, so `cond_code` reads 11 (busy) from the next cycle on. A channel end, a halt pulse or a halt instruction (`halt_ok`) ends the transfer, and `cond_code` then reads 00 from the next cycle on.
- R3: Incorrect length, `status[0]`. It is set when channel end arrives without count done having arrived in the same cycle or earlier. It is also set when count done arrives before channel end. If both arrive in the same cycle, it is not set.
- R4: `length_err` is 1 when `status[0]` is set and the suppress-length flag of the current command is 0. If that flag is 1, the status bit is still set but `length_err` stays 0.
- R5: Transmission data error, `status[1]`. Any bit of `ev_data_err` (parity or overrun) sets it.
- R6: Transmission memory error, `status[2]`. It is set by `ev_mem_parity`.
- R7: Address error, `status[3]`, is set by `ev_bad_addr`. Command fetch error, `status[4]`, is set by `ev_fetch_parity`.
- R8: Control error, `status[5]`. It is set when two command fetches in a row are both transfer-in-channel. Any other command fetch between them prevents it.
- R9: `halt_req` pulses for exactly one cycle, one cycle after the event, in three cases: an incorrect length while the suppress-length flag is 0 and the halt-on-error flag is 1; a data error while the halt-on-error flag is 1; a memory error while the halt-on-error flag is 1. In no other case does it pulse.
- R10: Status bits are sticky. They clear only on reset, `start_ok` or `halt_ok`. The clear takes effect in the next cycle.
- R11: Events that arrive while no transfer is active leave `status` and `halt_req` unchanged.
- R12: `cond_code` priority: `dev_fault` gives 01, which wins over everything. Otherwise an active transfer gives 11. Otherwise `other_owner` gives 10. Otherwise the code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_ok | input | 1 | Successful start instruction strobe |
| halt_ok | input | 1 | Successful halt instruction strobe |
| cmd_fetch | input | 1 | A command was fetched this cycle |
| cmd_tic | input | 1 | The fetched command is a transfer-in-channel |
| cmd_sup_len | input | 1 | Suppress-length flag of the fetched command |
| cmd_halt_err | input | 1 | Halt-on-error flag of the fetched command |
| ev_chan_end | input | 1 | Channel end / end of record strobe |
| ev_count_done | input | 1 | Byte count reached zero strobe |
| ev_data_err | input | DERR_W | Data parity / overrun strobes |
| ev_mem_parity | input | 1 | Memory parity error during data transfer |
| ev_bad_addr | input | 1 | Nonexistent address seen |
| ev_fetch_parity | input | 1 | Parity error while fetching a command |
| dev_fault | input | 1 | Controller not operational |
| other_owner | input | 1 | Controller held by another processor |
| status | output | 6 | Sticky status bits |
| length_err | output | 1 | Incorrect length counts as an error |
| halt_req | output | 1 | One-cycle device halt request |
| cond_code | output | 2 | Controller condition code |

## Verification
Every status bit and `halt_req` is registered. Each one is therefore due one cycle after the strobe that causes it. A halt pulse and the fall of busy arrive in that same cycle. `cond_code` and `length_err` follow the registered state combinationally, with no further delay. The bench drives strobes on the falling edge and holds them for one full cycle. It samples at the next falling edge, which is exactly the cycle in which results are due. A second sample one cycle later confirms that the halt pulse lasts only one cycle.

// File: rtl/sch_status_pkg.sv
package sch_status_pkg;
   localparam int ST_W     = 6;
   localparam int ST_LEN   = 0;
   localparam int ST_DATA  = 1;
   localparam int ST_MEM   = 2;
   localparam int ST_ADDR  = 3;
   localparam int ST_FETCH = 4;
   localparam int ST_CTL   = 5;

   typedef enum logic [1:0] {
      COND_READY   = 2'b00,
      COND_NOTOP   = 2'b01,
      COND_ELSEWHR = 2'b10,
      COND_BUSY    = 2'b11
   } cond_e;
endpackage

// File: rtl/sch_len_check.sv
module sch_len_check (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic active,
   input  logic chan_end,
   input  logic count_done,
   output logic len_ev
);
   logic count_seen_q;

   // Flag only the first mismatch of the transfer; a later channel end after
   // an early count done was already reported.
   assign len_ev = active & ~count_seen_q & (chan_end ^ count_done);

   always_ff @(posedge clk) begin
      if (rst || clr)
         count_seen_q <= 1'b0;
      else if (active && count_done)
         count_seen_q <= 1'b1;
   end
endmodule

// File: rtl/sch_sticky_bits.sv
module sch_sticky_bits #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [N-1:0] set,
   output logic [N-1:0] bits
);
   generate
      if (N < 1) begin : g_bad_n
         $error("sch_sticky_bits: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst || clr)
               bits[i] <= 1'b0;
            else if (set[i])
               bits[i] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sch_cond_encode.sv
module sch_cond_encode
   import sch_status_pkg::*;
(
   input  logic       fault,
   input  logic       active,
   input  logic       elsewhere,
   output logic [1:0] code
);
   cond_e c;
   always_comb begin
      if (fault)
         c = COND_NOTOP;
      else if (active)
         c = COND_BUSY;
      else if (elsewhere)
         c = COND_ELSEWHR;
      else
         c = COND_READY;
   end
   assign code = c;
endmodule

// File: rtl/sch_status_tracker.sv
module sch_status_tracker
   import sch_status_pkg::*;
#(
   parameter int DERR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_ok,
   input  logic              halt_ok,
   input  logic              cmd_fetch,
   input  logic              cmd_tic,
   input  logic              cmd_sup_len,
   input  logic              cmd_halt_err,
   input  logic              ev_chan_end,
   input  logic              ev_count_done,
   input  logic [DERR_W-1:0] ev_data_err,
   input  logic              ev_mem_parity,
   input  logic              ev_bad_addr,
   input  logic              ev_fetch_parity,
   input  logic              dev_fault,
   input  logic              other_owner,
   output logic [ST_W-1:0]   status,
   output logic              length_err,
   output logic              halt_req,
   output logic [1:0]        cond_code
);
   logic clr, active_q, sup_q, hte_q, prev_tic_q, halt_q;
   logic len_ev, data_ev, ctl_ev, halt_ev;
   logic [ST_W-1:0] set_vec;

   assign clr = start_ok | halt_ok;

   generate
      if (DERR_W < 1) begin : g_bad_w
         $error("sch_status_tracker: DERR_W must be at least 1");
      end
      if (DERR_W == 1) begin : g_derr_one
         assign data_ev = ev_data_err[0];
      end else begin : g_derr_many
         assign data_ev = |ev_data_err;
      end
   endgenerate

   sch_len_check u_len (
      .clk        (clk),
      .rst        (rst),
      .clr        (clr),
      .active     (active_q),
      .chan_end   (ev_chan_end),
      .count_done (ev_count_done),
      .len_ev     (len_ev)
   );

   assign ctl_ev = cmd_fetch & cmd_tic & prev_tic_q;

   always_comb begin
      set_vec           = '0;
      set_vec[ST_LEN]   = len_ev;
      set_vec[ST_DATA]  = data_ev;
      set_vec[ST_MEM]   = ev_mem_parity;
      set_vec[ST_ADDR]  = ev_bad_addr;
      set_vec[ST_FETCH] = ev_fetch_parity;
      set_vec[ST_CTL]   = ctl_ev;
      if (!active_q)
         set_vec = '0;
   end

   sch_sticky_bits #(.N(ST_W)) u_bits (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .set  (set_vec),
      .bits (status)
   );

   assign halt_ev = active_q & hte_q &
                    ((len_ev & ~sup_q) | data_ev | ev_mem_parity);

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q   <= 1'b0;
         sup_q      <= 1'b0;
         hte_q      <= 1'b0;
         prev_tic_q <= 1'b0;
         halt_q     <= 1'b0;
      end else begin
         halt_q <= halt_ev & ~clr;
         if (start_ok)
            active_q <= 1'b1;
         else if (halt_ok || ev_chan_end || halt_ev)
            active_q <= 1'b0;
         if (clr) begin
            sup_q      <= 1'b0;
            hte_q      <= 1'b0;
            prev_tic_q <= 1'b0;
         end else if (cmd_fetch) begin
            sup_q      <= cmd_sup_len;
            hte_q      <= cmd_halt_err;
            prev_tic_q <= cmd_tic;
         end
      end
   end

   assign halt_req   = halt_q;
   assign length_err = status[ST_LEN] & ~sup_q;

   sch_cond_encode u_cond (
      .fault     (dev_fault),
      .active    (active_q),
      .elsewhere (other_owner),
      .code      (cond_code)
   );
endmodule

// File: rtl/sch_status_tracker_chk.sv
module sch_status_tracker_chk (
   input logic       clk,
   input logic       rst,
   input logic       start_ok,
   input logic       halt_ok,
   input logic       dev_fault,
   input logic [5:0] status,
   input logic       halt_req,
   input logic [1:0] cond_code
);
   // R9: a halt is always backed by a halting status bit
   a_r9_halt_has_cause: assert property (@(posedge clk) disable iff (rst)
      halt_req |-> (status[2:0] != 3'b000));

   // R9: one-cycle pulse
   a_r9_halt_single: assert property (@(posedge clk) disable iff (rst)
      halt_req |=> !halt_req);

   // R2: a halt ends the transfer
   a_r2_halt_not_busy: assert property (@(posedge clk) disable iff (rst)
      halt_req |-> (cond_code != 2'b11));

   // R10: clear takes effect next cycle
   a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      (start_ok || halt_ok) |=> (status == 6'd0));

   // R10: bits never fall without a clear
   a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      (!start_ok && !halt_ok) |=> ((status & $past(status)) == $past(status)));

   // R12: fault dominates
   a_r12_fault: assert property (@(posedge clk) disable iff (rst)
      dev_fault |-> (cond_code == 2'b01));
endmodule

bind sch_status_tracker sch_status_tracker_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .start_ok  (start_ok),
   .halt_ok   (halt_ok),
   .dev_fault (dev_fault),
   .status    (status),
   .halt_req  (halt_req),
   .cond_code (cond_code)
);

// File: tb/sch_status_tracker_test.sv
module sch_status_tracker_test;
   logic clk = 1'b0;
   logic rst, start_ok, halt_ok, cmd_fetch, cmd_tic, cmd_sup_len, cmd_halt_err;
   logic ev_chan_end, ev_count_done, ev_mem_parity, ev_bad_addr, ev_fetch_parity;
   logic dev_fault, other_owner;
   logic [1:0] ev_data_err;
   logic [5:0] status;
   logic length_err, halt_req;
   logic [1:0] cond_code;
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sch_status_tracker #(.DERR_W(2)) uut (
      .clk(clk), .rst(rst), .start_ok(start_ok), .halt_ok(halt_ok),
      .cmd_fetch(cmd_fetch), .cmd_tic(cmd_tic), .cmd_sup_len(cmd_sup_len),
      .cmd_halt_err(cmd_halt_err), .ev_chan_end(ev_chan_end),
      .ev_count_done(ev_count_done), .ev_data_err(ev_data_err),
      .ev_mem_parity(ev_mem_parity), .ev_bad_addr(ev_bad_addr),
      .ev_fetch_parity(ev_fetch_parity), .dev_fault(dev_fault),
      .other_owner(other_owner), .status(status), .length_err(length_err),
      .halt_req(halt_req), .cond_code(cond_code)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_all();
      start_ok = 0; halt_ok = 0; cmd_fetch = 0; cmd_tic = 0;
      cmd_sup_len = 0; cmd_halt_err = 0; ev_chan_end = 0; ev_count_done = 0;
      ev_data_err = 0; ev_mem_parity = 0; ev_bad_addr = 0; ev_fetch_parity = 0;
   endtask

   // hold for one cycle, release; caller samples right after
   task automatic tick();
      @(negedge clk);
      idle_all();
   endtask

   task automatic do_start();
      start_ok = 1; tick();
   endtask

   task automatic do_cmd(input logic tic, input logic sup, input logic hte);
      cmd_fetch = 1; cmd_tic = tic; cmd_sup_len = sup; cmd_halt_err = hte; tick();
   endtask

   task automatic t_reset();
      rst = 1; idle_all(); dev_fault = 0; other_owner = 0;
      repeat (2) @(negedge clk);
      rst = 0; @(negedge clk);
      chk("R1 status", status, 0);
      chk("R1 halt", halt_req, 0);
      chk("R1 cond", cond_code, 0);
   endtask

   task automatic t_normal_end();
      do_start();
      chk("R2 busy", cond_code, 3);
      do_cmd(0, 0, 1);
      ev_chan_end = 1; ev_count_done = 1; tick();
      chk("R3 coincident no length", status, 0);
      chk("R9 no halt", halt_req, 0);
      chk("R2 ready after end", cond_code, 0);
   endtask

   task automatic t_short_halt();
      do_start(); do_cmd(0, 0, 1);
      ev_chan_end = 1; tick();
      chk("R3 early channel end", status, 6'h01);
      chk("R9 halt on length", halt_req, 1);
      chk("R4 length is error", length_err, 1);
      chk("R2 ready after halt", cond_code, 0);
      @(negedge clk);
      chk("R9 single pulse", halt_req, 0);
   endtask

   task automatic t_long_suppressed();
      do_start(); do_cmd(0, 1, 1);
      ev_count_done = 1; tick();
      chk("R3 count before end", status, 6'h01);
      chk("R9 suppressed no halt", halt_req, 0);
      chk("R4 suppressed not error", length_err, 0);
      chk("R2 still busy", cond_code, 3);
      ev_chan_end = 1; tick();
      chk("R9 no halt on later end", halt_req, 0);
      chk("R2 ready", cond_code, 0);
   endtask

   task automatic t_data_err();
      do_start(); do_cmd(0, 0, 0);
      ev_data_err = 2'b01; tick();
      chk("R5 parity sets", status, 6'h02);
      chk("R9 no halt without flag", halt_req, 0);
      do_cmd(0, 0, 1);
      ev_data_err = 2'b10; tick();
      chk("R9 overrun halts", halt_req, 1);
      chk("R10 sticky data", status, 6'h02);
   endtask

   task automatic t_mem_err();
      do_start(); do_cmd(0, 0, 0);
      ev_mem_parity = 1; tick();
      chk("R6 mem sets", status, 6'h04);
      chk("R9 mem no halt", halt_req, 0);
      do_start();
      chk("R10 start clears", status, 0);
      do_cmd(0, 0, 1);
      ev_mem_parity = 1; tick();
      chk("R9 mem halts", halt_req, 1);
   endtask

   task automatic t_addr_fetch();
      do_start(); do_cmd(0, 0, 1);
      ev_bad_addr = 1; tick();
      chk("R7 addr sets", status, 6'h08);
      chk("R9 addr no halt", halt_req, 0);
      ev_fetch_parity = 1; tick();
      chk("R7 fetch sets", status, 6'h18);
      halt_ok = 1; tick();
      chk("R10 halt clears", status, 0);
      chk("R2 halt ends busy", cond_code, 0);
   endtask

   task automatic t_ctl();
      do_start(); do_cmd(1, 0, 0); do_cmd(0, 0, 0); do_cmd(1, 0, 0);
      chk("R8 separated no error", status, 0);
      do_cmd(1, 0, 0);
      chk("R8 back to back", status, 6'h20);
      halt_ok = 1; tick();
   endtask

   task automatic t_idle_ignore();
      ev_chan_end = 1; ev_data_err = 2'b11; ev_mem_parity = 1;
      ev_bad_addr = 1; ev_fetch_parity = 1; tick();
      chk("R11 idle status", status, 0);
      chk("R11 idle halt", halt_req, 0);
   endtask

   task automatic t_cond();
      other_owner = 1; #1;
      chk("R12 elsewhere", cond_code, 2);
      do_start();
      chk("R12 busy over elsewhere", cond_code, 3);
      dev_fault = 1; #1;
      chk("R12 fault wins", cond_code, 1);
      dev_fault = 0; other_owner = 0;
      halt_ok = 1; tick();
   endtask

   initial begin
      t_reset();
      t_normal_end();
      t_short_halt();
      t_long_suppressed();
      t_data_err();
      t_mem_err();
      t_addr_fetch();
      t_ctl();
      t_idle_ignore();
      t_cond();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule